// File: doc/BRIEF.md
# CPU Clock Source Switch Sequencer

This block owns the two select fields of a CPU clock multiplexer tree and runs the steps for a change of CPU frequency. A request gives a target frequency in MHz. The block first checks the request. An accepted request moves the CPU clock onto the alternate PLL. The block then writes a new multiplier to the main PLL and waits for that PLL to lock. Last, it selects the path the CPU clock will run from.

Targets from the divide threshold upward run the main PLL at the target rate, reached through the droop-detection path. Lower targets, down to half the threshold, lock the main PLL at twice the target. Their clock then passes through the divide-by-two input of the secondary mux. Both select fields can be read back at any time as one combined control word.

Requests enter on a valid/ready handshake. `req_ready` is high only while the block is idle. A request offered while it is low is not taken and not stored: the source has to hold it or drop it. Nothing in the block waits on anything downstream.

Top module: `cpuclk_switch_seq`

## Requirements
- R1: After reset the primary select is 3 (alternate PLL) and the secondary select is 0 (reference oscillator). The multiplier output is 0, `req_ready` is high, and `busy`, `done`, `pll_load`, `err_range` and `err_lock` are low.
- R2: `req_ready` equals the inverse of `busy`. A request is taken only on an edge where `req_valid` and `req_ready` are both high. A `req_valid` offered while busy has no effect on any output and is not queued.
- R3: A target below 300 MHz is rejected. On the cycle after the accepting edge, `err_range` is high for one cycle. Both selects and the multiplier keep their values, and `busy` stays low.
- R4: A target whose PLL rate would exceed 3000 MHz is rejected in the same way as R3. The PLL rate is the target if the target is 600 MHz or more, and twice the target otherwise.
- R5: At the accepting edge of a valid target, the primary select becomes 3 and `busy` rises. The primary select stays 3 until the lock is seen.
- R6: SETTLE+1 edges after the parking edge, `pll_mult` takes floor(PLL rate / REF_MHZ) and `pll_load` pulses for one cycle. With the defaults, REF_MHZ is 19 and SETTLE is 3.
- R7: For a target of 600 MHz or more, the primary select is set to 2 at the edge where the lock is seen. The secondary select is left as it was.
- R8: For a target from 300 to 599 MHz, the secondary select is set to 1 at the lock edge. SETTLE+1 edges later, the primary select is set to 0.
- R9: `pll_lock` is ignored on the edge that ends the `pll_load` cycle. After that, it is sampled on LOCK_TIMEOUT consecutive edges. A high lock on the last of these edges still counts.
- R10: If no lock is seen in that window, `err_lock` pulses for one cycle and `busy` falls. The primary select stays 3 and `done` does not pulse.
- R11: `done` is a one-cycle pulse on the cycle after the edge that writes the final select. `busy` falls at that same edge. `done`, `err_range` and `err_lock` are never high together.
- R12: `mux_ctrl[1:0]` is the primary select and `mux_ctrl[3:2]` is the secondary select. The primary encoding is: 0 secondary mux, 1 main PLL direct, 2 main PLL through the droop path, 3 alternate PLL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Frequency request is offered |
| req_ready | output | 1 | Block can accept a request (idle) |
| req_mhz | input | FREQ_W (12) | Target frequency in MHz |
| pll_lock | input | 1 | Main PLL lock indication |
| pll_mult | output | MULT_W (8) | Multiplier for the main PLL |
| pll_load | output | 1 | One-cycle strobe: `pll_mult` has a new value |
| mux_ctrl | output | 4 | Combined select word: secondary [3:2], primary [1:0] |
| busy | output | 1 | A frequency change is in progress |
| done | output | 1 | One-cycle pulse: final select applied |
| err_range | output | 1 | One-cycle pulse: target rejected |
| err_lock | output | 1 | One-cycle pulse: PLL lock timed out |

## Verification
The bench targets the edges of the frequency windows: 299, 300, 599, 600, 3000 and 3001 MHz. Each is reachable by an off-by-one compare. A design that gets one wrong would pick the wrong final path, or would park the clock and reprogram the PLL for a target it should reject.

Other stimulus covers:
- a lock that is already high when the multiplier is loaded, which a design that skips the load-cycle guard would take too early;
- a lock that never arrives, where the clock must stay parked;
- requests offered while busy, which a design that queues them would act on;
- a change from half rate back to full rate, which exposes a design that wrongly resets the secondary select.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;

  typedef enum logic [1:0] {
    PS_SECONDARY  = 2'd0,
    PS_PLL_DIRECT = 2'd1,
    PS_PLL_DROOP  = 2'd2,
    PS_ALT_PLL    = 2'd3
  } prim_sel_e;

  localparam logic [1:0] SS_REF      = 2'd0;
  localparam logic [1:0] SS_PLL_HALF = 2'd1;

  localparam int SEL_W   = 2;
  localparam int NUM_SEL = 2;
  localparam int CTRL_W  = SEL_W * NUM_SEL;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_PARK,
    SQ_LOCK,
    SQ_SEC
  } seq_state_e;

endpackage

// File: rtl/cpuclk_rate_plan.sv
module cpuclk_rate_plan #(
  parameter int FREQ_W      = 12,
  parameter int MULT_W      = 8,
  parameter int REF_MHZ     = 19,
  parameter int DIV_MHZ     = 600,
  parameter int MIN_MHZ     = 300,
  parameter int PLL_MIN_MHZ = 600,
  parameter int PLL_MAX_MHZ = 3000
) (
  input  logic [FREQ_W-1:0] target_mhz,
  output logic              plan_ok,
  output logic              plan_half,
  output logic [MULT_W-1:0] plan_mult
);

  logic [31:0] tgt;
  logic [31:0] rate;

  always_comb begin
    tgt       = 32'(target_mhz);
    plan_half = (tgt < 32'(DIV_MHZ));
    rate      = plan_half ? (tgt << 1) : tgt;
    plan_ok   = (tgt >= 32'(MIN_MHZ)) &&
                (rate >= 32'(PLL_MIN_MHZ)) &&
                (rate <= 32'(PLL_MAX_MHZ));
    plan_mult = MULT_W'(rate / 32'(REF_MHZ));
  end

endmodule

// File: rtl/cpuclk_wait_timer.sv
module cpuclk_wait_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (run && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/cpuclk_sel_field.sv
module cpuclk_sel_field #(
  parameter int             W       = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_VAL;
    end else if (we) begin
      q <= wdata;
    end
  end

endmodule

// File: rtl/cpuclk_seq_ctrl.sv
module cpuclk_seq_ctrl
  import cpuclk_pkg::*;
#(
  parameter int MULT_W       = 8,
  parameter int CNT_W        = 7,
  parameter int SETTLE       = 3,
  parameter int LOCK_TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              plan_ok,
  input  logic              plan_half,
  input  logic [MULT_W-1:0] plan_mult,
  input  logic              pll_lock,
  input  logic              tmr_expired,
  output logic              req_ready,
  output logic              busy,
  output logic              done,
  output logic              err_range,
  output logic              err_lock,
  output logic [MULT_W-1:0] pll_mult,
  output logic              pll_load,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output logic              tmr_run,
  output logic              prim_we,
  output logic [SEL_W-1:0]  prim_wdata,
  output logic              sec_we,
  output logic [SEL_W-1:0]  sec_wdata
);

  seq_state_e        state, next_state;
  logic              half_q;
  logic [MULT_W-1:0] mult_q;
  logic              take, reject, load_go, finish, timeout;

  assign req_ready = (state == SQ_IDLE);
  assign take      = req_ready && req_valid && plan_ok;
  assign reject    = req_ready && req_valid && !plan_ok;

  always_comb begin
    next_state = state;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    tmr_run    = 1'b0;
    prim_we    = 1'b0;
    prim_wdata = PS_ALT_PLL;
    sec_we     = 1'b0;
    sec_wdata  = SS_REF;
    load_go    = 1'b0;
    finish     = 1'b0;
    timeout    = 1'b0;
    unique case (state)
      SQ_IDLE: begin
        if (take) begin
          prim_we    = 1'b1;
          prim_wdata = PS_ALT_PLL;
          tmr_load   = 1'b1;
          tmr_val    = CNT_W'(SETTLE);
          next_state = SQ_PARK;
        end
      end
      SQ_PARK: begin
        tmr_run = 1'b1;
        if (tmr_expired) begin
          load_go    = 1'b1;
          tmr_load   = 1'b1;
          tmr_val    = CNT_W'(LOCK_TIMEOUT);
          next_state = SQ_LOCK;
        end
      end
      SQ_LOCK: begin
        tmr_run = 1'b1;
        if (pll_lock && !pll_load) begin
          if (half_q) begin
            sec_we     = 1'b1;
            sec_wdata  = SS_PLL_HALF;
            tmr_load   = 1'b1;
            tmr_val    = CNT_W'(SETTLE);
            next_state = SQ_SEC;
          end else begin
            prim_we    = 1'b1;
            prim_wdata = PS_PLL_DROOP;
            finish     = 1'b1;
            next_state = SQ_IDLE;
          end
        end else if (tmr_expired) begin
          timeout    = 1'b1;
          next_state = SQ_IDLE;
        end
      end
      SQ_SEC: begin
        tmr_run = 1'b1;
        if (tmr_expired) begin
          prim_we    = 1'b1;
          prim_wdata = PS_SECONDARY;
          finish     = 1'b1;
          next_state = SQ_IDLE;
        end
      end
      default: next_state = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      half_q    <= 1'b0;
      mult_q    <= '0;
      pll_mult  <= '0;
      pll_load  <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      err_range <= 1'b0;
      err_lock  <= 1'b0;
    end else begin
      state     <= next_state;
      busy      <= (next_state != SQ_IDLE);
      done      <= finish;
      err_range <= reject;
      err_lock  <= timeout;
      pll_load  <= load_go;
      if (take) begin
        half_q <= plan_half;
        mult_q <= plan_mult;
      end
      if (load_go) begin
        pll_mult <= mult_q;
      end
    end
  end

endmodule

// File: rtl/cpuclk_switch_seq.sv
module cpuclk_switch_seq
  import cpuclk_pkg::*;
#(
  parameter int FREQ_W        = 12,
  parameter int REF_MHZ       = 19,
  parameter int DIV_MHZ       = 600,
  parameter int MIN_MHZ       = 300,
  parameter int PLL_MIN_MHZ   = 600,
  parameter int PLL_MAX_MHZ   = 3000,
  parameter int SETTLE        = 3,
  parameter int LOCK_TIMEOUT  = 64,
  localparam int MULT_W       = $clog2(PLL_MAX_MHZ / REF_MHZ + 1),
  localparam int WAIT_MAX     = (SETTLE > LOCK_TIMEOUT) ? SETTLE : LOCK_TIMEOUT,
  localparam int CNT_W        = $clog2(WAIT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [FREQ_W-1:0] req_mhz,
  input  logic              pll_lock,
  output logic [MULT_W-1:0] pll_mult,
  output logic              pll_load,
  output logic [CTRL_W-1:0] mux_ctrl,
  output logic              busy,
  output logic              done,
  output logic              err_range,
  output logic              err_lock
);

  localparam logic [CTRL_W-1:0] CTRL_RST = {SS_REF, PS_ALT_PLL};

  logic              plan_ok, plan_half;
  logic [MULT_W-1:0] plan_mult;
  logic              tmr_load, tmr_run, tmr_expired;
  logic [CNT_W-1:0]  tmr_val;
  logic                           prim_we, sec_we;
  logic [SEL_W-1:0]               prim_wdata, sec_wdata;
  logic [NUM_SEL-1:0]             fld_we;
  logic [NUM_SEL-1:0][SEL_W-1:0]  fld_wdata;

  cpuclk_rate_plan #(
    .FREQ_W(FREQ_W), .MULT_W(MULT_W), .REF_MHZ(REF_MHZ), .DIV_MHZ(DIV_MHZ),
    .MIN_MHZ(MIN_MHZ), .PLL_MIN_MHZ(PLL_MIN_MHZ), .PLL_MAX_MHZ(PLL_MAX_MHZ)
  ) plan_i (
    .target_mhz(req_mhz),
    .plan_ok   (plan_ok),
    .plan_half (plan_half),
    .plan_mult (plan_mult)
  );

  cpuclk_wait_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .load_val(tmr_val),
    .run     (tmr_run),
    .expired (tmr_expired)
  );

  cpuclk_seq_ctrl #(
    .MULT_W(MULT_W), .CNT_W(CNT_W), .SETTLE(SETTLE), .LOCK_TIMEOUT(LOCK_TIMEOUT)
  ) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .plan_ok    (plan_ok),
    .plan_half  (plan_half),
    .plan_mult  (plan_mult),
    .pll_lock   (pll_lock),
    .tmr_expired(tmr_expired),
    .req_ready  (req_ready),
    .busy       (busy),
    .done       (done),
    .err_range  (err_range),
    .err_lock   (err_lock),
    .pll_mult   (pll_mult),
    .pll_load   (pll_load),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .tmr_run    (tmr_run),
    .prim_we    (prim_we),
    .prim_wdata (prim_wdata),
    .sec_we     (sec_we),
    .sec_wdata  (sec_wdata)
  );

  assign fld_we    = {sec_we, prim_we};
  assign fld_wdata = {sec_wdata, prim_wdata};

  for (genvar gi = 0; gi < NUM_SEL; gi++) begin : g_sel
    cpuclk_sel_field #(
      .W(SEL_W), .RST_VAL(CTRL_RST[gi*SEL_W +: SEL_W])
    ) fld_i (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (fld_we[gi]),
      .wdata(fld_wdata[gi]),
      .q    (mux_ctrl[gi*SEL_W +: SEL_W])
    );
  end

endmodule

// File: rtl/cpuclk_switch_seq_chk.sv
module cpuclk_switch_seq_chk #(
  parameter int CTRL_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              pll_load,
  input logic [CTRL_W-1:0] mux_ctrl,
  input logic              busy,
  input logic              done,
  input logic              err_range,
  input logic              err_lock
);

  AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == !busy); // R2

  AST_REJECT_KEEPS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    err_range |-> $stable(mux_ctrl)); // R3

  AST_LOAD_WHILE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    pll_load |-> (mux_ctrl[1:0] == 2'd3)); // R5

  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pll_load |=> !pll_load); // R6

  AST_FINAL_PATH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((mux_ctrl[1:0] == 2'd0) || (mux_ctrl[1:0] == 2'd2))); // R7

  AST_HALF_PATH_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (mux_ctrl[1:0] == 2'd0)) |-> (mux_ctrl[3:2] == 2'd1)); // R8

  AST_TIMEOUT_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    err_lock |-> ((mux_ctrl[1:0] == 2'd3) && !busy)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R11

  AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err_range, err_lock})); // R11

endmodule

bind cpuclk_switch_seq cpuclk_switch_seq_chk #(.CTRL_W(CTRL_W)) chk_i (.*);

// File: tb/cpuclk_switch_seq_tb_top.sv
module cpuclk_switch_seq_tb_top;

  localparam int REF     = 19;
  localparam int SET     = 3;
  localparam int TMO     = 64;
  localparam int LK_DLY  = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [11:0] req_mhz = '0;
  logic       pll_lock = 1'b0;
  logic       req_ready, pll_load, busy, done, err_range, err_lock;
  logic [7:0] pll_mult;
  logic [3:0] mux_ctrl;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cpuclk_switch_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mhz(req_mhz), .pll_lock(pll_lock), .pll_mult(pll_mult),
    .pll_load(pll_load), .mux_ctrl(mux_ctrl), .busy(busy), .done(done),
    .err_range(err_range), .err_lock(err_lock)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_phase = 0;   // 0 idle, 1 parked, 2 awaiting lock, 3 secondary settle
  int m_left  = 0;
  int m_prim  = 3, m_sec = 0, m_mult = 0;
  bit m_load = 0, m_busy = 0, m_done = 0, m_erng = 0, m_elock = 0, m_half = 0;
  int m_pend_mult = 0;

  task automatic plan(input int t, output bit ok, output bit half, output int rate);
    half = (t < 600);
    rate = half ? 2 * t : t;
    ok   = (t >= 300) && (rate >= 600) && (rate <= 3000);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_left = 0; m_prim = 3; m_sec = 0; m_mult = 0;
      m_load = 0; m_busy = 0; m_done = 0; m_erng = 0; m_elock = 0;
    end else begin
      bit prev_load, ok, half;
      int rate;
      prev_load = m_load;
      m_load = 0; m_done = 0; m_erng = 0; m_elock = 0;
      case (m_phase)
        0: if (req_valid) begin
             plan(int'(req_mhz), ok, half, rate);
             if (!ok) m_erng = 1;
             else begin
               m_prim = 3; m_busy = 1; m_phase = 1; m_left = SET;
               m_half = half; m_pend_mult = rate / REF;
             end
           end
        1: if (m_left == 0) begin
             m_mult = m_pend_mult; m_load = 1; m_phase = 2; m_left = TMO;
           end else m_left--;
        2: if (pll_lock && !prev_load) begin
             if (m_half) begin m_sec = 1; m_phase = 3; m_left = SET; end
             else begin m_prim = 2; m_done = 1; m_busy = 0; m_phase = 0; end
           end else if (m_left == 0) begin
             m_elock = 1; m_busy = 0; m_phase = 0;
           end else m_left--;
        default: if (m_left == 0) begin
             m_prim = 0; m_done = 1; m_busy = 0; m_phase = 0;
           end else m_left--;
      endcase
    end
  end

  // cycle compare and event counters
  int n_done = 0, n_erng = 0, n_elock = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2",  "req_ready", int'(req_ready), int'(m_phase == 0));
      check("R5",  "busy",      int'(busy),      int'(m_busy));
      check("R11", "done",      int'(done),      int'(m_done));
      check("R3",  "err_range", int'(err_range), int'(m_erng));
      check("R10", "err_lock",  int'(err_lock),  int'(m_elock));
      check("R12", "mux_ctrl",  int'(mux_ctrl),  m_sec * 4 + m_prim);
      check("R6",  "pll_mult",  int'(pll_mult),  m_mult);
      check("R9",  "pll_load",  int'(pll_load),  int'(m_load));
      if (done) n_done++;
      if (err_range) n_erng++;
      if (err_lock) n_elock++;
    end
  end

  // PLL lock emulation: 0 normal, 1 never locks, 2 always high
  int lock_mode = 0;
  int lk_cnt = 0;
  always @(negedge clk) begin
    case (lock_mode)
      1: pll_lock = 1'b0;
      2: pll_lock = 1'b1;
      default: begin
        if (pll_load) begin pll_lock = 1'b0; lk_cnt = LK_DLY; end
        else if (lk_cnt > 0) lk_cnt--;
        else pll_lock = 1'b1;
      end
    endcase
  end

  task automatic send(input int mhz);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_mhz   = 12'(mhz);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_ok(input string tag, input int mhz, input int exp_mux, input int exp_mult);
    int d0;
    d0 = n_done;
    send(mhz);
    wait_idle();
    check(tag, "final mux_ctrl", int'(mux_ctrl), exp_mux);
    check(tag, "multiplier", int'(pll_mult), exp_mult);
    check(tag, "done pulses", n_done - d0, 1);
  endtask

  task automatic run_reject(input string tag, input int mhz, input int exp_mux);
    int e0;
    e0 = n_erng;
    send(mhz);
    check(tag, "busy after reject", int'(busy), 0);
    wait_idle();
    check(tag, "err_range pulses", n_erng - e0, 1);
    check(tag, "mux unchanged", int'(mux_ctrl), exp_mux);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "reset mux_ctrl", int'(mux_ctrl), 3);
    check("R1", "reset multiplier", int'(pll_mult), 0);
    check("R1", "reset ready", int'(req_ready), 1);
    check("R1", "reset status", int'({busy, done, err_range, err_lock, pll_load}), 0);

    run_ok("R7", 1200, 4'b0010, 1200 / REF);
    run_ok("R8", 450,  4'b0100, 900 / REF);
    run_ok("R7", 600,  4'b0110, 600 / REF);   // secondary keeps 1
    run_ok("R8", 599,  4'b0100, 1198 / REF);
    run_ok("R8", 300,  4'b0100, 600 / REF);
    run_reject("R3", 299, 4'b0100);
    run_reject("R3", 0,   4'b0100);
    run_ok("R4", 3000, 4'b0110, 3000 / REF);
    run_reject("R4", 3001, 4'b0110);

    // R2: requests offered while busy are dropped
    begin
      int e0, d0;
      e0 = n_erng; d0 = n_done;
      send(1200);
      @(negedge clk);
      req_valid = 1'b1; req_mhz = 12'd299;
      repeat (4) @(negedge clk);
      req_mhz = 12'd450;
      repeat (4) @(negedge clk);
      req_valid = 1'b0;
      wait_idle();
      check("R2", "no reject while busy", n_erng - e0, 0);
      check("R2", "single completion", n_done - d0, 1);
      check("R2", "mux from first request", int'(mux_ctrl), 4'b0110);
    end

    // R10: lock never arrives
    begin
      int l0, d0;
      l0 = n_elock; d0 = n_done;
      lock_mode = 1;
      send(800);
      wait_idle();
      check("R10", "err_lock pulses", n_elock - l0, 1);
      check("R10", "no done", n_done - d0, 0);
      check("R10", "still parked", int'(mux_ctrl[1:0]), 3);
      check("R10", "multiplier written", int'(pll_mult), 800 / REF);
    end

    // R9: lock already high at load time
    lock_mode = 2;
    run_ok("R9", 700, 4'b0110, 700 / REF);
    lock_mode = 0;
    run_ok("R8", 350, 4'b0100, 700 / REF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R11 watchdog: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule